// File: doc/BRIEF.md
# Grouped Exception Priority Sequencer

This block arbitrates the exception requests of a small processor core. Eight request lines arrive from around the core: the exception-reset request, address error, bus error, trace, external interrupt, illegal opcode, privilege violation, and a single instruction-generated trap line. The trap line stands for trap, overflow trap, bounds check and divide faults, which never coincide because only one instruction runs at a time. Each request is latched as pending. The block then issues one start strobe per chosen exception, together with its code, and aborts the instruction in flight when a fatal error is taken.

The requests fall into three classes, each with its own start timing. The fatal class (reset, address error, bus error) starts two clock edges after the request is sampled, whatever the instruction is doing. The boundary class (trace, interrupt, illegal, privilege) starts only at an instruction boundary. Once a boundary has been seen, every pending boundary-class request is started, one after another, before execution may resume. The trap class starts as soon as nothing more urgent is pending. A busy line from the stacking logic holds off new starts, but a fatal error still cuts into a sequence of a lower class. Taking the exception-reset request discards everything else.

Top module: `exc_seq`

## Requirements
- R1: While rst_n is low, and after it is released with no requests, exc_start, exc_sel, exc_code and abort_insn are all zero.
- R2: Exception codes are: 0 reset, 1 address error, 2 bus error, 3 trace, 4 interrupt, 5 illegal, 6 privilege, 7 trap. exc_start is high for one cycle per exception started, exc_code carries the code, and exc_sel has exactly bit exc_code set. exc_sel is zero when exc_start is low.
- R3: A fatal-class request sampled at clock edge k starts at edge k+1, so exc_start is visible after the second edge, with or without a boundary. Among pending fatal requests, reset is taken before address error, and address error before bus error.
- R4: abort_insn is high exactly when exc_start is high with a code of 0, 1 or 2.
- R5: A boundary-class exception starts only in a cycle with insn_boundary high, or while a boundary is being held. The boundary hold lasts as long as stack_busy is high or any request is pending. The order is trace, then interrupt, then illegal, then privilege, started one per cycle until none is left.
- R6: A pending trap starts without a boundary once no fatal request is pending and stack_busy is low. At a boundary, pending boundary-class requests are taken first.
- R7: A pending trap is discarded, and never started, when an address error, bus error, illegal or privilege request is pending alongside it.
- R8: Starting the reset exception clears every other pending request and the boundary hold. No start follows in the next cycle.
- R9: While stack_busy is high, no boundary-class or trap exception starts. Address and bus errors are held off by stack_busy only when the previous start was a fatal one. Reset ignores stack_busy.
- R10: A request stays pending after its input falls until it is started, discarded by R7 or R8, or rst_n is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| req_reset | input | 1 | Exception-reset request |
| req_addr_err | input | 1 | Address error request |
| req_bus_err | input | 1 | Bus error request |
| req_trace | input | 1 | Trace request |
| req_irq | input | 1 | External interrupt request |
| req_illegal | input | 1 | Illegal opcode request |
| req_priv | input | 1 | Privilege violation request |
| req_trap | input | 1 | Instruction-generated trap request |
| insn_boundary | input | 1 | High in the cycle an instruction completes |
| stack_busy | input | 1 | Stacking logic is processing an exception |
| exc_start | output | 1 | One-cycle start strobe |
| exc_code | output | 3 | Code of the started exception (R2) |
| exc_sel | output | 8 | One-hot form of exc_code |
| abort_insn | output | 1 | Abort the instruction in progress |

## Verification
On every cycle the assertions check the shape of the strobe and the select, that abort follows fatal starts only, and that busy keeps lower classes out. They also check that boundary-class starts come only from a boundary or its hold, that a reset start has its request two edges earlier and is followed by a quiet cycle. Only the bench scenarios can show that the order of a chained sequence is right. The same holds for a discarded trap never starting and a lone interrupt waiting for a boundary. They also cover the exact release cycle after busy falls, and requests that a reset start has flushed.

// File: rtl/exc_seq.sv
module exc_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_reset,
  input  logic       req_addr_err,
  input  logic       req_bus_err,
  input  logic       req_trace,
  input  logic       req_irq,
  input  logic       req_illegal,
  input  logic       req_priv,
  input  logic       req_trap,
  input  logic       insn_boundary,
  input  logic       stack_busy,
  output logic       exc_start,
  output logic [2:0] exc_code,
  output logic [7:0] exc_sel,
  output logic       abort_insn
);
  localparam int NE = 8;
  localparam int CW = $clog2(NE);

  logic [NE-1:0] req, pend, clr;
  logic          run_g0, bnd_hold;
  logic          fire, at_bnd, g0_any, g1_any, trap_kill;
  logic [CW-1:0] pick;

  assign req = {req_trap, req_priv, req_illegal, req_irq,
                req_trace, req_bus_err, req_addr_err, req_reset};

  assign g0_any    = |pend[2:0];
  assign g1_any    = |pend[6:3];
  assign at_bnd    = insn_boundary | bnd_hold;
  assign trap_kill = pend[1] | pend[2] | pend[5] | pend[6];

  always_comb begin
    fire = 1'b0;
    pick = '0;
    if (pend[0]) begin
      fire = 1'b1;
      pick = CW'(0);
    end else if (g0_any) begin
      if (!(stack_busy && run_g0)) begin
        fire = 1'b1;
        pick = pend[1] ? CW'(1) : CW'(2);
      end
    end else if (!stack_busy) begin
      if (at_bnd && g1_any) begin
        fire = 1'b1;
        if (pend[3])      pick = CW'(3);
        else if (pend[4]) pick = CW'(4);
        else if (pend[5]) pick = CW'(5);
        else              pick = CW'(6);
      end else if (pend[7] && !trap_kill) begin
        fire = 1'b1;
        pick = CW'(7);
      end
    end
  end

  assign clr = (fire ? (NE'(1) << pick) : '0) | {trap_kill, {(NE-1){1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend       <= '0;
      run_g0     <= 1'b0;
      bnd_hold   <= 1'b0;
      exc_start  <= 1'b0;
      exc_code   <= '0;
      exc_sel    <= '0;
      abort_insn <= 1'b0;
    end else begin
      if (fire && pick == CW'(0)) begin
        pend     <= '0;
        bnd_hold <= 1'b0;
      end else begin
        pend     <= (pend & ~clr) | req;
        bnd_hold <= at_bnd && (fire || stack_busy || (|pend[6:0]));
      end
      if (fire) run_g0 <= (pick <= CW'(2));
      exc_start  <= fire;
      exc_code   <= fire ? pick : '0;
      exc_sel    <= fire ? (NE'(1) << pick) : '0;
      abort_insn <= fire && (pick <= CW'(2));
    end
  end
endmodule

// File: rtl/exc_seq_chk.sv
module exc_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       exc_start,
  input logic [2:0] exc_code,
  input logic [7:0] exc_sel,
  input logic       abort_insn,
  input logic       stack_busy,
  input logic       insn_boundary,
  input logic       bnd_hold,
  input logic       req_reset
);
  // R2
  sel_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_start ? (exc_sel == (8'd1 << exc_code)) : (exc_sel == 8'd0));

  // R4
  abort_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_insn == (exc_start && exc_code <= 3'd2));

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stack_busy |=> !(exc_start && exc_code >= 3'd3));

  // R5
  boundary_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_start && exc_code >= 3'd3 && exc_code <= 3'd6) |-> ($past(insn_boundary) || $past(bnd_hold)));

  // R3
  reset_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_start && exc_code == 3'd0) |-> $past(req_reset, 2));

  // R8
  reset_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_start && exc_code == 3'd0) |=> !exc_start);
endmodule

bind exc_seq exc_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .exc_start(exc_start), .exc_code(exc_code),
  .exc_sel(exc_sel), .abort_insn(abort_insn), .stack_busy(stack_busy),
  .insn_boundary(insn_boundary), .bnd_hold(bnd_hold), .req_reset(req_reset)
);

// File: tb/sim_exc_seq.sv
`timescale 1ns/100ps
module sim_exc_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] req = '0;
  logic bnd = 1'b0, busy = 1'b0;
  logic exc_start, abort_insn;
  logic [2:0] exc_code;
  logic [7:0] exc_sel;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  exc_seq u0 (
    .clk(clk), .rst_n(rst_n),
    .req_reset(req[0]), .req_addr_err(req[1]), .req_bus_err(req[2]),
    .req_trace(req[3]), .req_irq(req[4]), .req_illegal(req[5]),
    .req_priv(req[6]), .req_trap(req[7]),
    .insn_boundary(bnd), .stack_busy(busy),
    .exc_start(exc_start), .exc_code(exc_code), .exc_sel(exc_sel),
    .abort_insn(abort_insn)
  );

  // {request mask (bit = code), boundary in the following cycle, start order, F = none}
  localparam logic [24:0] VEC [12] = '{
    {8'h18, 1'b1, 16'h34FF},
    {8'h84, 1'b0, 16'h2FFF},
    {8'h06, 1'b0, 16'h12FF},
    {8'hFF, 1'b1, 16'h0FFF},
    {8'hA0, 1'b1, 16'h5FFF},
    {8'h80, 1'b0, 16'h7FFF},
    {8'h70, 1'b1, 16'h456F},
    {8'h10, 1'b0, 16'hFFFF},
    {8'h1A, 1'b1, 16'h134F},
    {8'hC0, 1'b1, 16'h6FFF},
    {8'h88, 1'b0, 16'h7FFF},
    {8'h88, 1'b1, 16'h37FF}
  };

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req = '0; bnd = 1'b0; busy = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic expect_start(string tag, logic [2:0] code);
    chk(exc_start && exc_code == code, tag, {exc_start, exc_code}, {1'b1, code});
  endtask

  task automatic expect_idle(string tag);
    chk(!exc_start, tag, exc_start, 0);
  endtask

  initial begin
    do_reset();
    chk(!exc_start && exc_sel == 0 && exc_code == 0 && !abort_insn, "R1 reset state",
        {exc_start, abort_insn, exc_sel, exc_code}, 0);

    // table: R2 R3 R5 R6 R7 R8 orderings
    for (int i = 0; i < 12; i++) begin
      logic [24:0] v;
      logic [15:0] got;
      int n;
      v = VEC[i];
      do_reset();
      req = v[24:17];
      @(negedge clk);
      req = '0; bnd = v[16];
      @(negedge clk);
      bnd = 1'b0;
      got = 16'hFFFF; n = 0;
      for (int c = 0; c < 6; c++) begin
        if (exc_start) begin
          if (n < 4) got[15-4*n -: 4] = {1'b0, exc_code};
          n++;
          chk(exc_sel == (8'd1 << exc_code) && abort_insn == (exc_code <= 3'd2),
              "R2 R4 select/abort", {abort_insn, exc_sel}, {exc_code <= 3'd2, 8'd1 << exc_code});
        end
        @(negedge clk);
      end
      chk(got == v[15:0] && n <= 4, $sformatf("R5 R6 R7 order vector %0d", i), got, v[15:0]);
    end

    // R3 fatal latency and R4 abort
    do_reset();
    req = 8'h04;
    @(negedge clk); req = '0;
    expect_idle("R3 not before second edge");
    @(negedge clk);
    expect_start("R3 bus error start", 3'd2);
    chk(abort_insn, "R4 abort on bus error", abort_insn, 1);

    // R9 busy holds boundary class, R5 hold keeps boundary
    do_reset();
    busy = 1'b1; req = 8'h08;
    @(negedge clk); req = '0; bnd = 1'b1;
    @(negedge clk); bnd = 1'b0;
    expect_idle("R9 busy blocks trace");
    @(negedge clk);
    expect_idle("R9 still blocked");
    busy = 1'b0;
    @(negedge clk);
    expect_start("R5 held boundary releases trace", 3'd3);
    chk(!abort_insn, "R4 no abort on trace", abort_insn, 0);

    // R9 bus error preempts a boundary-class sequence
    do_reset();
    req = 8'h08;
    @(negedge clk); req = '0; bnd = 1'b1;
    @(negedge clk); bnd = 1'b0;
    expect_start("R5 trace at boundary", 3'd3);
    busy = 1'b1; req = 8'h04;
    @(negedge clk); req = '0;
    @(negedge clk);
    expect_start("R9 bus error preempts busy", 3'd2);

    // R9 fatal after fatal waits for busy
    do_reset();
    req = 8'h06;
    @(negedge clk); req = '0;
    @(negedge clk);
    expect_start("R3 address error first", 3'd1);
    busy = 1'b1;
    @(negedge clk);
    expect_idle("R9 bus error held by busy");
    @(negedge clk);
    expect_idle("R9 bus error still held");
    busy = 1'b0;
    @(negedge clk);
    expect_start("R9 bus error after busy", 3'd2);

    // R8 reset ignores busy and flushes
    do_reset();
    busy = 1'b1; req = 8'h11;
    @(negedge clk); req = '0;
    @(negedge clk);
    expect_start("R8 reset despite busy", 3'd0);
    busy = 1'b0; bnd = 1'b1;
    @(negedge clk); bnd = 1'b0;
    expect_idle("R8 interrupt flushed");
    @(negedge clk);
    expect_idle("R8 interrupt stays flushed");

    // R10 request held until boundary
    do_reset();
    req = 8'h10;
    @(negedge clk); req = '0;
    repeat (3) @(negedge clk);
    expect_idle("R10 interrupt waits");
    bnd = 1'b1;
    @(negedge clk); bnd = 1'b0;
    expect_start("R10 held interrupt taken", 3'd4);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule